// File: doc/BRIEF.md
# Calendar Clock with Freeze-for-Read Registers

This block keeps wall-clock time and date (seconds, minutes, hours, day of week, date, month, two-digit year) in packed BCD. A divider turns a 32,768 Hz enable pulse into one-second advances of the internal counter chain. Software does not read the counters directly. It reads a bank of eight byte registers at the top of a memory-mapped window, and that bank is a copy refreshed from the counters.

Software sets a freeze bit in the control byte to hold the copy steady. This gives a coherent multi-byte read while the real counters keep counting. To set the clock, software raises a set bit, writes the new fields into the bank, and clears the set bit. The staged values then move into the counters in one step, and the sub-second divider restarts. A stop flag in the seconds byte halts the divider.

Top module: `rtc_freeze_clock`

## Requirements
- R1: The register window is the top eight addresses of a 2^ADDR_W byte space. Offset 0 is control, with bit 7 = SET, bit 6 = FREEZE and bits 5:0 reading 0. Offset 1 is seconds, with bit 7 = stop flag. Offsets 2 to 7 are minutes, hours, day of week, date, month and year, all packed BCD. A read with ce=1, oe=1, we=0 returns the byte on the next clock edge. Every other cycle, and any address outside the window, gives rdata = 0.
- R2: After reset, control reads 0x00 and the time reads 00:00:00, day 01, date 01, month 01, year 00, with the stop flag clear.
- R3: The counters advance one second every DIV enable pulses. Seconds and minutes wrap 59 to 00 with a carry, and hours wrap 23 to 00 with a carry.
- R4: Day of week counts 1 to 7 and then returns to 1. Date wraps after 31, 30 (months 04, 06, 09, 11) or February's 28. February has 29 days when the year is a multiple of 4, and year 00 counts as a multiple of 4. After date wraps, month wraps 12 to 01 and year wraps 99 to 00.
- R5: While FREEZE, SET and the release hold are all clear, every visible time byte is reloaded from the counters together, on the edge after each advance.
- R6: While FREEZE is 1, the visible bytes stay unchanged and the internal counters keep advancing.
- R7: A FREEZE write that lands on the same edge as a refresh does not block that refresh. The bank then holds the newly advanced time.
- R8: Clearing FREEZE starts a hold of exactly DIV enable pulses, and routine refreshes are suppressed during it. At the end of the hold the bank is reloaded with the counters' current value.
- R9: While SET is 1, bus writes to offsets 1 to 7 are captured into the bank. Clearing SET loads all counters in one step and restarts the divider, so the next advance comes DIV pulses later.
- R10: With SET at 0, writes to offsets 2 to 7 and to the seconds digits have no effect. Only the stop flag takes the written bit 7.
- R11: While the stop flag is 1, the divider and counters hold. Clearing the flag resumes counting from the held divider phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | 32,768 Hz enable pulse, one cycle wide |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| ce | input | 1 | Chip enable |
| we | input | 1 | Write enable (takes precedence over oe) |
| oe | input | 1 | Output enable |
| rdata | output | 8 | Registered read data, zero when not reading |

## Verification
Some properties are checked on every cycle: a frozen bank never changes, the bank stays put during a release hold, a refresh copies the counters exactly, a load takes the staged value, seconds wrap at 59, the counters hold between advances and while stopped, and idle read data is zero. Other behaviour is only visible through the bench's scenarios. These are the month-length and leap-year table across a sweep of years and months, the day-of-week wrap, and the race between a freeze write and a refresh on the same edge. They also include the exact one-second delay before the first refresh after release, and the resumed divider phase after a stop.

// File: rtl/rtc_pkg.sv
// Shared types and BCD helpers for the calendar clock.
// Assumes all time fields hold valid packed BCD.
package rtc_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    localparam rtc_time_t RTC_RESET_TIME = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                             dow: 8'h01, hour: 8'h00, min: 8'h00,
                                             sec: 8'h00};

    // Increment a two-digit BCD value (caller handles the field's wrap).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Leap test on a BCD year: tens*10 + ones is a multiple of 4 when (tens*2 + ones) is.
    function automatic logic bcd_leap(input logic [7:0] y);
        logic [7:0] s;
        s = {3'b000, y[7:4], 1'b0} + {4'b0000, y[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    // Last date of a BCD month.
    function automatic logic [7:0] month_last(input logic [7:0] m, input logic leap);
        case (m)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Modulo-DIV enable divider. Counts tick pulses while not held and pulses
// adv in the cycle its count reaches DIV-1. restart forces the count to zero.
// Assumes DIV >= 2.
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    input  logic restart,
    output logic adv
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Advance pulse: last count reached on a counted tick.
    assign adv = tick && !hold && !restart && (cnt == LAST);

    // Count register: restart, wrap, or step on each counted tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)   cnt <= '0;
        else if (tick && !hold)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/rtc_calendar.sv
// BCD time/date counter chain. On adv it steps one second with all carries,
// month lengths and leap years. On load it takes load_val in one step; load wins over adv.
// Assumes load_val holds valid BCD fields.
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t now
);
    rtc_time_t  nxt;
    logic [7:0] last_date;

    assign last_date = month_last(now.month, bcd_leap(now.year));

    // Next-second value with cascaded carries.
    always_comb begin
        nxt = now;
        if (now.sec != 8'h59) nxt.sec = bcd_inc(now.sec);
        else begin
            nxt.sec = 8'h00;
            if (now.min != 8'h59) nxt.min = bcd_inc(now.min);
            else begin
                nxt.min = 8'h00;
                if (now.hour != 8'h23) nxt.hour = bcd_inc(now.hour);
                else begin
                    nxt.hour = 8'h00;
                    nxt.dow  = (now.dow >= 8'h07) ? 8'h01 : now.dow + 8'h01;
                    if (now.date != last_date) nxt.date = bcd_inc(now.date);
                    else begin
                        nxt.date = 8'h01;
                        if (now.month != 8'h12) nxt.month = bcd_inc(now.month);
                        else begin
                            nxt.month = 8'h01;
                            nxt.year  = (now.year == 8'h99) ? 8'h00 : bcd_inc(now.year);
                        end
                    end
                end
            end
        end
    end

    // Counter state: reset, load, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)    now <= RTC_RESET_TIME;
        else if (load) now <= load_val;
        else if (adv)  now <= nxt;
    end

    a_r9_load_takes_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (now == $past(load_val)));
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && now.sec == 8'h59) |=> (now.sec == 8'h00));
    a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(now));

endmodule

// File: rtl/rtc_snapshot.sv
// Software-visible copy of the time. It takes bus field writes while the set
// bit is on, and copies all of live at once on a routine or release refresh when neither
// freeze nor set is on. A pending release hold blocks routine refreshes.
module rtc_snapshot
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rtc_time_t  live,
    input  logic       xfer,
    input  logic       rel_fire,
    input  logic       read_hold,
    input  logic       write_hold,
    input  logic       hold_rel,
    input  logic       fld_we,
    input  logic [2:0] fld_idx,
    input  logic [7:0] fld_data,
    output rtc_time_t  snap
);
    logic refresh;

    // A refresh is allowed only when neither freeze nor set holds the bank.
    assign refresh = !write_hold && !read_hold && (rel_fire || (xfer && !hold_rel));

    // Bank register: staged field writes or whole-bank refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) snap <= RTC_RESET_TIME;
        else if (write_hold && fld_we) begin
            case (fld_idx)
                3'd1:    snap.sec   <= {1'b0, fld_data[6:0]};
                3'd2:    snap.min   <= fld_data;
                3'd3:    snap.hour  <= fld_data;
                3'd4:    snap.dow   <= fld_data;
                3'd5:    snap.date  <= fld_data;
                3'd6:    snap.month <= fld_data;
                3'd7:    snap.year  <= fld_data;
                default: ;
            endcase
        end
        else if (refresh) snap <= live;
    end

    a_r6_freeze_holds_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (read_hold && !write_hold) |=> $stable(snap));

endmodule

// File: rtl/rtc_freeze_clock.sv
// Top of the calendar clock: byte-bus decode of the eight-byte window, control
// bits (set, freeze), stop flag, release-hold tracking and registered read data.
// Assumes tick is a one-cycle enable at 32,768 Hz and DIV pulses make one second.
module rtc_freeze_clock
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DIV    = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              ce,
    input  logic              we,
    input  logic              oe,
    output logic [7:0]        rdata
);
    localparam int OFF_W = 3;

    logic             in_win, wr, rd, ctrl_wr, time_wr, load, clear_ev;
    logic [OFF_W-1:0] off;
    logic             set_q, frz_q, stop_q, hold_rel, xfer_q;
    logic             adv, rel_fire;
    rtc_time_t        live, snap;

    assign in_win   = &addr[ADDR_W-1:OFF_W];
    assign off      = addr[OFF_W-1:0];
    assign wr       = ce && we && in_win;
    assign rd       = ce && oe && !we && in_win;
    assign ctrl_wr  = wr && (off == 3'd0);
    assign time_wr  = wr && (off != 3'd0);
    assign load     = ctrl_wr && set_q && !wdata[7];
    assign clear_ev = ctrl_wr && frz_q && !wdata[6];

    rtc_prescaler #(.DIV(DIV)) u_sec_div (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hold(stop_q),
        .restart(load), .adv(adv));

    rtc_prescaler #(.DIV(DIV)) u_rel_div (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hold(!hold_rel),
        .restart(clear_ev), .adv(rel_fire));

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .adv(adv), .load(load),
        .load_val(snap), .now(live));

    rtc_snapshot u_bank (
        .clk(clk), .rst_n(rst_n), .live(live), .xfer(xfer_q),
        .rel_fire(rel_fire), .read_hold(frz_q), .write_hold(set_q),
        .hold_rel(hold_rel), .fld_we(time_wr), .fld_idx(off),
        .fld_data(wdata), .snap(snap));

    // Control bits, stop flag, release hold and refresh strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q    <= 1'b0;
            frz_q    <= 1'b0;
            stop_q   <= 1'b0;
            hold_rel <= 1'b0;
            xfer_q   <= 1'b0;
        end else begin
            xfer_q <= adv;
            if (ctrl_wr) begin
                set_q <= wdata[7];
                frz_q <= wdata[6];
            end
            if (wr && off == 3'd1) stop_q <= wdata[7];
            if (clear_ev)          hold_rel <= 1'b1;
            else if (rel_fire)     hold_rel <= 1'b0;
        end
    end

    // Registered read mux; zero when no read is addressed.
    always_ff @(posedge clk) begin
        if (!rst_n || !rd) rdata <= 8'h00;
        else begin
            case (off)
                3'd0:    rdata <= {set_q, frz_q, 6'b0};
                3'd1:    rdata <= {stop_q, snap.sec[6:0]};
                3'd2:    rdata <= snap.min;
                3'd3:    rdata <= snap.hour;
                3'd4:    rdata <= snap.dow;
                3'd5:    rdata <= snap.date;
                3'd6:    rdata <= snap.month;
                default: rdata <= snap.year;
            endcase
        end
    end

    a_r1_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce && oe && !we) |=> (rdata == 8'h00));
    a_r5_refresh_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_q && !frz_q && !set_q && !hold_rel) |=> (snap == $past(live)));
    a_r8_release_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_rel && !rel_fire && !set_q) |=> $stable(snap));
    a_r11_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !load) |=> $stable(live));

endmodule

// File: tb/tb_rtc_freeze_clock.sv
module tb_rtc_freeze_clock;
    localparam int ADDR_W = 17;
    localparam int DIV    = 16;
    localparam logic [ADDR_W-1:0] BASE = 17'h1FFF8;

    typedef struct { int s, mi, h, dw, dt, mo, y; } bt_t;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] wdata = 8'h00;
    logic ce = 1'b0, we = 1'b0, oe = 1'b0;
    logic [7:0] rdata;
    int cyc = 0, nchk = 0, nerr = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_freeze_clock #(.ADDR_W(ADDR_W), .DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wdata(wdata),
        .ce(ce), .we(we), .oe(oe), .rdata(rdata));

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic bt_t step(input bt_t t);
        bt_t n = t;
        n.s++;
        if (n.s == 60) begin n.s = 0; n.mi++; end
        if (n.mi == 60) begin n.mi = 0; n.h++; end
        if (n.h == 24) begin
            n.h = 0;
            n.dw = (n.dw == 7) ? 1 : n.dw + 1;
            n.dt++;
            if (n.dt > dim(n.mo, n.y)) begin n.dt = 1; n.mo++; end
            if (n.mo == 13) begin n.mo = 1; n.y = (n.y + 1) % 100; end
        end
        return n;
    endfunction

    function automatic logic [7:0] field(input bt_t t, input int off);
        case (off)
            1: return bcd(t.s);
            2: return bcd(t.mi);
            3: return bcd(t.h);
            4: return bcd(t.dw);
            5: return bcd(t.dt);
            6: return bcd(t.mo);
            default: return bcd(t.y);
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Bus tasks start and end just after a falling edge.
    task automatic wr(input int off, input logic [7:0] d, output int edge_no);
        addr = BASE + ADDR_W'(off); wdata = d; ce = 1'b1; we = 1'b1; oe = 1'b0;
        edge_no = cyc + 1;
        @(posedge clk); @(negedge clk);
        ce = 1'b0; we = 1'b0;
    endtask

    task automatic rd_addr(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        addr = a; ce = 1'b1; oe = 1'b1; we = 1'b0;
        @(posedge clk); @(negedge clk);
        d = rdata; ce = 1'b0; oe = 1'b0;
    endtask

    task automatic rd(input int off, output logic [7:0] d);
        rd_addr(BASE + ADDR_W'(off), d);
    endtask

    task automatic wait_until(input int e);
        while (cyc + 1 < e) @(negedge clk);
    endtask

    task automatic load_time(input bt_t t, output int cl);
        int e;
        wr(0, 8'h80, e);
        for (int k = 1; k < 8; k++) wr(k, field(t, k), e);
        wr(0, 8'h00, cl);
    endtask

    task automatic read_all(input string tag, input bt_t t);
        logic [7:0] d;
        for (int k = 1; k < 8; k++) begin
            rd(k, d);
            chk($sformatf("%s off%0d", tag, k), d, field(t, k));
        end
    endtask

    // One rollover case: load, wait one advance plus refresh, read the bank.
    task automatic roll_case(input string tag, input bt_t t);
        int cl;
        logic [7:0] d;
        load_time(t, cl);
        wait_until(cl + DIV + 2);
        read_all(tag, step(t));
        rd(0, d);
        chk({tag, " control"}, d, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int cl, e, cs, cu, cc;
        bt_t t0, t;
        int years[4] = '{0, 23, 24, 99};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        rd(0, d); chk("R2 control", d, 8'h00);
        rd(1, d); chk("R2 seconds", d, 8'h00);
        rd(4, d); chk("R2 day", d, 8'h01);
        rd(5, d); chk("R2 date", d, 8'h01);
        rd(6, d); chk("R2 month", d, 8'h01);
        rd(7, d); chk("R2 year", d, 8'h00);

        // R1 outside the window reads zero
        rd_addr(17'h00010, d); chk("R1 outside window", d, 8'h00);

        // R3 time carries
        t = '{s:59, mi:59, h:9,  dw:2, dt:3,  mo:5, y:24}; roll_case("R3 hour carry", t);
        t = '{s:59, mi:34, h:12, dw:5, dt:8,  mo:7, y:24}; roll_case("R3 minute carry", t);
        t = '{s:9,  mi:0,  h:19, dw:1, dt:9,  mo:1, y:23}; roll_case("R3 digit carry", t);
        t = '{s:59, mi:59, h:23, dw:7, dt:14, mo:8, y:23}; roll_case("R4 day wrap", t);

        // R4 month ends over several years, plus February 28
        foreach (years[i]) begin
            for (int m = 1; m <= 12; m++) begin
                t = '{s:59, mi:59, h:23, dw:(m % 7) + 1, dt:dim(m, years[i]), mo:m, y:years[i]};
                roll_case($sformatf("R4 y%0d m%0d", years[i], m), t);
            end
            t = '{s:59, mi:59, h:23, dw:3, dt:28, mo:2, y:years[i]};
            roll_case($sformatf("R4 feb28 y%0d", years[i]), t);
        end

        // R9 load, R5 refresh timing, R7 race, R6 freeze, R8 release
        t0 = '{s:50, mi:59, h:11, dw:3, dt:15, mo:6, y:24};
        load_time(t0, cl);
        rd(1, d); chk("R9 staged value loaded", d, 8'h50);
        wait_until(cl + DIV + 1);
        rd(1, d); chk("R5 before refresh edge", d, 8'h50);
        rd(1, d); chk("R5 after refresh edge", d, 8'h51);
        wait_until(cl + 3 * DIV + 1);
        wr(0, 8'h40, e);
        rd(1, d); chk("R7 refresh completes under freeze", d, 8'h53);
        wait_until(cl + 6 * DIV + 5);
        t = t0;
        for (int k = 0; k < 3; k++) t = step(t);
        read_all("R6 frozen bank", t);
        rd(0, d); chk("R6 control freeze bit", d, 8'h40);
        wait_until(cl + 7 * DIV + 2);
        wr(0, 8'h00, cc);
        wait_until(cc + DIV);
        rd(1, d); chk("R8 still held before one second", d, 8'h53);
        rd(1, d); chk("R8 refreshed after one second", d, 8'h58);
        t = t0;
        for (int k = 0; k < 8; k++) t = step(t);
        read_all("R6 counters kept running", t);

        // R10 ignored writes, R11 stop flag
        t0 = '{s:0, mi:30, h:8, dw:2, dt:10, mo:3, y:23};
        load_time(t0, cl);
        wait_until(cl + DIV + 3);
        wr(2, 8'h45, e);
        wait_until(cl + DIV + 5);
        wr(1, 8'h80, cs);
        wait_until(cs + 3 * DIV);
        rd(1, d); chk("R11 stopped seconds with flag", d, 8'h81);
        rd(2, d); chk("R10 minutes write ignored", d, 8'h30);
        wr(1, 8'h00, cu);
        wait_until(cu + 14);
        rd(1, d); chk("R11 resumed count", d, 8'h02);
        rd(2, d); chk("R10 minutes after resume", d, 8'h30);

        // R1 unused control bits read zero
        wr(0, 8'h3F, e);
        rd(0, d); chk("R1 control low bits", d, 8'h00);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule